// File: doc/BRIEF.md
# Ring Indicator Pulse-Train Filter

This block conditions three active-low ring-indicate lines for use as wake-up sources. Channel 0 is the dedicated ring line. Channels 1 and 2 are the ring lines of two serial ports. A small select register, written through a byte-wide configuration port, chooses the mode of each channel on its own.

In edge mode, a channel reports every high-to-low transition of its pin as a single-clock low pulse.

In train mode, a channel waits for a ringing pattern before it reports anything. The pattern is a run of falling edges that arrive at least as fast as the minimum ring frequency (15 Hz by default) and that lasts for the qualification time (200 ms by default). Once the run qualifies, the output goes low and stays low for as long as the toggling goes on. When no new edge arrives within one minimum-frequency period, the output returns high.

The block runs from a slow timebase clock. Periods and durations are counted in ticks of that clock. The tick counts are derived from the parameters `TICK_HZ`, `MIN_RING_HZ` and `QUAL_MS`. With the defaults (1000, 15, 200), the longest allowed spacing between falling edges is `GAP_TICKS` = 67 ticks and the qualification time is `QUAL_TICKS` = 200 ticks.

Top module: `ring_wake_filter`

## Requirements
- R1: The select register answers at configuration index 0xC6. It is read back on `cfg_rdata` whenever `cfg_addr` is 0xC6 and resets to 0x00. A write with any other index leaves it unchanged.
- R2: Select bit i sets the mode of channel i (bit 0 is the dedicated ring line, bits 1 and 2 are the serial-port lines). A value of 1 selects train mode and 0 selects edge mode. Bits 7:3 always read as 0.
- R3: In edge mode, consider a pin sampled low at clock edge k after being sampled high at edge k-1. Its output is low for exactly the one cycle after edge k+2 and high otherwise.
- R4: Toggling counts as continuing while successive detected falling edges are at most `GAP_TICKS` clocks apart. A spacing of exactly `GAP_TICKS` keeps the train alive. A spacing of `GAP_TICKS`+1 ends it.
- R5: In train mode, let the first detected fall of a train be the train start. The output goes low `QUAL_TICKS`+1 clocks after the train start if the train is still alive, and it stays low while the train is alive.
- R6: In train mode, the output returns high `GAP_TICKS`+1 clocks after the last detected fall of a train.
- R7: A train that ends before `QUAL_TICKS` clocks have elapsed never drives the output low. This covers a 10 Hz train and a short 20 Hz burst. The next fall after a train has ended restarts qualification from zero.
- R8: The channels are independent. Mode, qualification and release on one channel do not depend on activity on any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock; one rising edge per tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the configuration port |
| cfg_addr | input | 8 | Configuration index |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for the selected index (0 for other indices) |
| ring_in_n | input | 3 | Asynchronous active-low ring inputs, bit i feeds channel i |
| ring_out_n | output | 3 | Conditioned active-low ring indications, one per channel |

## Verification
Two of the train logic's functions can fall in the same clock: the arrival of a new falling edge and the expiry of the gap timer. The fall must win, so the train stays alive and qualification is not reset. The bench provokes this with trains whose falls are spaced exactly `GAP_TICKS` apart, which must qualify, and spaced `GAP_TICKS`+1 apart, which must never qualify. A cycle-by-cycle reference built from fall timestamps judges the output on every clock. The same reference runs while a train channel and an edge channel toggle together, so a sharing bug between channels also shows up as a mismatch.

// File: rtl/ring_filt_pkg.sv
package ring_filt_pkg;

  typedef enum logic {
    MODE_EDGE  = 1'b0,
    MODE_TRAIN = 1'b1
  } ring_mode_e;

  // longest fall-to-fall spacing, in ticks, that still counts as toggling
  function automatic int unsigned gap_ticks(input int unsigned tick_hz,
                                            input int unsigned min_hz);
    return (tick_hz + min_hz - 1) / min_hz;
  endfunction

  // qualification time in ticks
  function automatic int unsigned qual_ticks(input int unsigned tick_hz,
                                             input int unsigned ms);
    return (tick_hz * ms) / 1000;
  endfunction

endpackage

// File: rtl/ring_sel_reg.sv
module ring_sel_reg #(
  parameter int unsigned CH    = 3,
  parameter logic [7:0]  INDEX = 8'hC6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [7:0]    addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o,
  output logic [CH-1:0] sel_o
);
  logic hit;
  assign hit = (addr_i == INDEX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sel_o <= '0;
    else if (wr_i && hit) sel_o <= wdata_i[CH-1:0];
  end

  assign rdata_o = hit ? {{(8-CH){1'b0}}, sel_o} : 8'h00;

  p_write_takes_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && hit) |=> (sel_o == $past(wdata_i[CH-1:0])));
  p_foreign_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !hit) |=> $stable(sel_o));
endmodule

// File: rtl/ring_edge_sync.sv
module ring_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n_i,
  output logic fall_o
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      meta_q <= pin_n_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign fall_o = prev_q & ~sync_q;

  p_fall_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);
endmodule

// File: rtl/ring_train_qual.sv
module ring_train_qual #(
  parameter int unsigned GAP_TICKS  = 67,
  parameter int unsigned QUAL_TICKS = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fall_i,
  input  logic train_mode_i,
  output logic out_n_o
);
  localparam int unsigned GW = $clog2(GAP_TICKS + 1);
  localparam int unsigned QW = $clog2(QUAL_TICKS + 1);
  localparam logic [GW-1:0] GAP_LAST = GW'(GAP_TICKS - 1);
  localparam logic [QW-1:0] QUAL_MAX = QW'(QUAL_TICKS);

  logic          alive_q;
  logic [GW-1:0] gap_q;
  logic [QW-1:0] qual_q;
  logic          gap_expire;
  logic          qualified;
  logic [QW-1:0] qual_step;

  assign gap_expire = alive_q && !fall_i && (gap_q == GAP_LAST);
  assign qual_step  = (qual_q == QUAL_MAX) ? qual_q : qual_q + QW'(1);
  assign qualified  = alive_q && (qual_q == QUAL_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alive_q <= 1'b0;
      gap_q   <= '0;
      qual_q  <= '0;
    end else if (fall_i) begin
      alive_q <= 1'b1;
      gap_q   <= '0;
      qual_q  <= alive_q ? qual_step : '0;
    end else if (gap_expire) begin
      alive_q <= 1'b0;
      gap_q   <= '0;
      qual_q  <= '0;
    end else if (alive_q) begin
      gap_q   <= gap_q + GW'(1);
      qual_q  <= qual_step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       out_n_o <= 1'b1;
    else if (train_mode_i) out_n_o <= !qualified;
    else              out_n_o <= !fall_i;
  end

  p_gap_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    alive_q |-> (gap_q < GW'(GAP_TICKS)));
  p_fall_beats_expiry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_i && alive_q && gap_q == GAP_LAST) |=> alive_q);
  p_qualify_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (train_mode_i && qualified) |=> !out_n_o);
  p_release_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (train_mode_i && $fell(alive_q)) |=> out_n_o);
  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_i && !alive_q) |=> (qual_q == '0));
  p_edge_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!train_mode_i && !out_n_o) |=> (out_n_o || train_mode_i));
endmodule

// File: rtl/ring_wake_filter.sv
module ring_wake_filter #(
  parameter int unsigned TICK_HZ     = 1000,
  parameter int unsigned MIN_RING_HZ = 15,
  parameter int unsigned QUAL_MS     = 200,
  parameter logic [7:0]  SEL_INDEX   = 8'hC6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [7:0] cfg_addr,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  input  logic [2:0] ring_in_n,
  output logic [2:0] ring_out_n
);
  import ring_filt_pkg::*;

  localparam int unsigned NCH        = 3;
  localparam int unsigned GAP_TICKS  = gap_ticks(TICK_HZ, MIN_RING_HZ);
  localparam int unsigned QUAL_TICKS = qual_ticks(TICK_HZ, QUAL_MS);

  logic [NCH-1:0] sel;
  logic [NCH-1:0] fall;

  ring_sel_reg #(.CH(NCH), .INDEX(SEL_INDEX)) u_sel (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (cfg_wr),
    .addr_i  (cfg_addr),
    .wdata_i (cfg_wdata),
    .rdata_o (cfg_rdata),
    .sel_o   (sel)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    ring_mode_e mode;
    assign mode = ring_mode_e'(sel[g]);

    ring_edge_sync u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_n_i (ring_in_n[g]),
      .fall_o  (fall[g])
    );

    ring_train_qual #(.GAP_TICKS(GAP_TICKS), .QUAL_TICKS(QUAL_TICKS)) u_qual (
      .clk          (clk),
      .rst_n        (rst_n),
      .fall_i       (fall[g]),
      .train_mode_i (mode == MODE_TRAIN),
      .out_n_o      (ring_out_n[g])
    );
  end

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[7:3] == 5'd0);
endmodule

// File: tb/ring_wake_filter_bench.sv
module ring_wake_filter_bench;
  localparam int GAP  = 67;
  localparam int QUAL = 200;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_addr = 8'h00;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic [2:0] ring_in_n = 3'b111;
  logic [2:0] ring_out_n;

  always #2.5 clk = ~clk;

  ring_wake_filter u_ring_wake_filter (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .ring_in_n(ring_in_n), .ring_out_n(ring_out_n));

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // reference: timestamps of detected falls per channel
  typedef struct { int cyc; logic [2:0] exp; } exp_t;
  exp_t sb[$];
  logic [2:0] sel_shadow = 3'b000;
  int  n = 0;
  bit  hist [3][4];
  int  last_fall [3];
  int  start [3];
  bit  seen [3];
  bit  saw_low [3];

  initial begin
    for (int c = 0; c < 3; c++) begin
      for (int j = 0; j < 4; j++) hist[c][j] = 1'b1;
      seen[c] = 1'b0; last_fall[c] = 0; start[c] = 0; saw_low[c] = 1'b0;
    end
  end

  // driver side: predicts the output for the next edge and queues it
  always @(posedge clk) begin
    if (rst_n) begin
      exp_t e;
      n++;
      e.cyc = n + 1;
      for (int c = 0; c < 3; c++) begin
        bit fall_now, fall_next, alive_before, alive_now, qual;
        hist[c][3] = hist[c][2]; hist[c][2] = hist[c][1];
        hist[c][1] = hist[c][0]; hist[c][0] = ring_in_n[c];
        fall_now  = !hist[c][2] && hist[c][3];
        fall_next = !hist[c][1] && hist[c][2];
        alive_before = seen[c] && ((n - 1 - last_fall[c]) < GAP);
        if (fall_now) begin
          if (!alive_before) start[c] = n;
          last_fall[c] = n;
          seen[c] = 1'b1;
        end
        alive_now = seen[c] && ((n - last_fall[c]) < GAP);
        qual = alive_now && ((n - start[c]) >= QUAL);
        e.exp[c] = sel_shadow[c] ? !qual : !fall_next;
      end
      sb.push_back(e);
    end
  end

  // monitor: compares the ring outputs against the queue away from the edge
  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < 3; c++) if (!ring_out_n[c]) saw_low[c] = 1'b1;
      while (sb.size() > 0 && sb[0].cyc <= n) begin
        exp_t e;
        e = sb.pop_front();
        if (e.cyc == n) begin
          for (int c = 0; c < 3; c++) begin
            string tag;
            tag = !sel_shadow[c] ? "R3" : (!e.exp[c] ? "R5" : "R6");
            check(ring_out_n[c] === e.exp[c], tag, $sformatf("ch%0d cyc%0d", c, n),
                  ring_out_n[c], e.exp[c]);
          end
        end
      end
    end
  end

  task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic cfg_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  task automatic set_mode(input logic [2:0] m);
    cfg_write(8'hC6, {5'd0, m});
    sel_shadow = m;
  endtask

  task automatic train(input int ch, input int period, input int low, input int count);
    for (int k = 0; k < count; k++) begin
      @(negedge clk); ring_in_n[ch] = 1'b0;
      repeat (low - 1) @(negedge clk);
      @(negedge clk); ring_in_n[ch] = 1'b1;
      repeat (period - low - 1) @(negedge clk);
    end
  endtask

  task automatic idle_clear();
    repeat (GAP + 20) @(negedge clk);
    for (int c = 0; c < 3; c++) saw_low[c] = 1'b0;
  endtask

  initial begin
    logic [7:0] rd;
    repeat (4) @(negedge clk);
    check(ring_out_n === 3'b111, "R1", "outputs idle in reset", ring_out_n, 7);
    rst_n = 1'b1;
    cfg_read(8'hC6, rd);
    check(rd === 8'h00, "R1", "select reset value", rd, 0);
    cfg_write(8'hC6, 8'hFF);
    cfg_read(8'hC6, rd);
    check(rd === 8'h07, "R2", "reserved bits read zero", rd, 7);
    cfg_write(8'hC5, 8'h00);
    cfg_read(8'hC6, rd);
    check(rd === 8'h07, "R1", "foreign index write ignored", rd, 7);
    cfg_read(8'hC7, rd);
    check(rd === 8'h00, "R1", "foreign index reads zero", rd, 0);
    set_mode(3'b000);
    cfg_read(8'hC6, rd);
    check(rd === 8'h00, "R1", "select cleared", rd, 0);
    idle_clear();

    // edge mode on every channel
    fork
      train(1, 8, 3, 4);
      train(0, 11, 5, 3);
    join
    idle_clear();

    // train mode: 20 Hz long train qualifies and then releases
    set_mode(3'b111);
    train(0, 50, 25, 8);
    repeat (GAP + 10) @(negedge clk);
    check(saw_low[0] == 1'b1, "R5", "20 Hz train asserted", saw_low[0], 1);
    check(ring_out_n[0] === 1'b1, "R6", "released after train", ring_out_n[0], 1);
    idle_clear();

    // 10 Hz never qualifies
    train(1, 100, 50, 6);
    repeat (GAP) @(negedge clk);
    check(saw_low[1] == 1'b0, "R7", "10 Hz train never asserted", saw_low[1], 0);
    idle_clear();

    // short 20 Hz burst never qualifies
    train(2, 50, 25, 3);
    repeat (GAP) @(negedge clk);
    check(saw_low[2] == 1'b0, "R7", "short burst never asserted", saw_low[2], 0);
    idle_clear();

    // spacing boundary: exactly GAP keeps alive, GAP+1 ends
    train(0, GAP, 10, 5);
    repeat (GAP) @(negedge clk);
    check(saw_low[0] == 1'b1, "R4", "spacing GAP qualifies", saw_low[0], 1);
    idle_clear();
    train(0, GAP + 1, 10, 6);
    repeat (GAP) @(negedge clk);
    check(saw_low[0] == 1'b0, "R4", "spacing GAP+1 never qualifies", saw_low[0], 0);
    idle_clear();

    // mixed modes in parallel
    set_mode(3'b101);
    fork
      train(0, 50, 25, 8);
      train(1, 30, 4, 5);
      train(2, 100, 50, 5);
    join
    repeat (GAP + 10) @(negedge clk);
    check(saw_low[0] == 1'b1, "R8", "ch0 train asserted", saw_low[0], 1);
    check(saw_low[1] == 1'b1, "R8", "ch1 edge pulses seen", saw_low[1], 1);
    check(saw_low[2] == 1'b0, "R8", "ch2 slow train quiet", saw_low[2], 0);
    idle_clear();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule